// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives the six gate signals of a three-phase inverter bridge. One shared timer counts up from zero to the period value and then back down, so each PWM period is symmetric around its start. Each phase compares the timer against its own duty register. The result is a complementary high-side and low-side pair. A programmable dead time keeps the two switches of a leg from conducting together.

Duty and period values are written through a simple register port into shadow registers. They move into the working copies only at reload points. A reload point is the start of each period, plus the midpoint when double-update mode is selected. Each reload point emits a synchronization pulse of programmable width.

A trip input shuts all outputs off in hardware. A software shutdown bit does the same. After either one, the outputs come back only at a period boundary. Further options are an output polarity input, a switched-reluctance input that makes each low side follow its high side, and gate chopping that can be enabled separately for the high side and the low side. A status vector reports the pin levels, the timer half and whether the outputs are disabled.

Top module: `cpwm3_top`

## Requirements
- R1: While reset is asserted and directly after it, all six outputs sit at their inactive level, `sync_o` is low, `status_o[4]` is 1, and the period register reads 16.
- R2: The timer counts P cycles up and P cycles down, where P is the period register (address 0). This gives a PWM period of 2P clock cycles, and period starts (sync rising in the first half) are 2P cycles apart. A period value below 2 acts as 2.
- R3: With zero dead time, a phase with duty D (0 < D < P) holds its high side active for 2D cycles per period and its low side for 2(P-D) cycles. The high-side window is centered on the period start. Duty registers live at address 8+i for phase i.
- R4: Dead time register DT (address 1, low 8 bits) delays every turn-on edge by 2*DT cycles. Per period the high side is then active 2D-2*DT cycles and the low side 2(P-D)-2*DT cycles. Outside switched-reluctance mode, both outputs of a phase are never active together.
- R5: A duty of P or more keeps the high side active for the whole period with the low side never active. A duty of 0 does the opposite. No dead-time gap appears in either case.
- R6: Mode register (address 3) bit 0 selects the update mode. At 0, duty values written during a period take effect at the next period start. At 1, they also take effect at the midpoint, so a value written in the first half already governs the second half.
- R7: A sync pulse starts on the first cycle after each reload point: once per period in single-update mode and twice in double-update mode. It lasts W cycles, where W is the low 8 bits of address 2 (0 acts as 1). In single-update mode it rises only in the first half.
- R8: `trip_i` high forces all six outputs inactive in the same cycle. The shutdown is latched. The outputs stay inactive after the trip falls, until the shutdown register (address 5) is written with bit 0 = 0. They then resume at the next period start.
- R9: Writing address 5 with bit 0 = 1 makes all outputs inactive from the next cycle on. Writing bit 0 = 0 releases them at the next period start.
- R10: `pol_i` = 1 makes outputs active-high. `pol_i` = 0 makes them active-low, with an idle level of 1.
- R11: With `sr_n_i` low, each low-side output follows its high-side output cycle for cycle.
- R12: Gate register (address 4) bit 0 chops the high side and bit 1 chops the low side. The carrier has a period of 2*(bits 15:8 + 1) cycles. A chopped output is active only in the carrier's high half, and the other side is left as it was.
- R13: `status_o` bits are {disabled, second half, `sr_n_i`, `pol_i`, `trip_i`}, with bit 0 = trip. Bit 3 is 1 while the timer counts down. `rd_data` returns the last value written to the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | DATA_W | Read data of the addressed register |
| trip_i | input | 1 | Hardware trip, active high |
| pol_i | input | 1 | Output polarity, 1 = active high |
| sr_n_i | input | 1 | Switched-reluctance select, active low |
| hi_o | output | NPH | High-side gate outputs |
| lo_o | output | NPH | Low-side gate outputs |
| sync_o | output | 1 | Reload synchronization pulse |
| status_o | output | 5 | Disabled, second half, sr_n, pol, trip |

## Verification
The bench targets the edges where a comparator design most often slips.

- **Duty 0 and duty of P or more.** A wrong compare leaves a one-cycle sliver, or a spurious dead-time gap, in a leg that should be steady.
- **Dead time.** It is checked against segments that straddle the period boundary. A design that trims both edges of a segment, or none, shows the wrong on-count.
- **Update mode.** A duty change is written in the first half and the two halves are measured separately. This exposes a design that ignores the midpoint reload, or applies it in single-update mode.
- **Trip and shutdown release.** The bench confirms that outputs stay off after the trip falls and until the next period start after release. A design that restarts mid-period shows active cycles before the boundary.

// File: rtl/cpwm3_pkg.sv
package cpwm3_pkg;
   localparam int ADDR_W = 4;
   localparam int STAT_W = 5;
   localparam logic [ADDR_W-1:0] A_PERIOD = 4'd0;
   localparam logic [ADDR_W-1:0] A_DEAD   = 4'd1;
   localparam logic [ADDR_W-1:0] A_SYNCW  = 4'd2;
   localparam logic [ADDR_W-1:0] A_MODE   = 4'd3;
   localparam logic [ADDR_W-1:0] A_GATE   = 4'd4;
   localparam logic [ADDR_W-1:0] A_SHDN   = 4'd5;
   localparam int                A_DUTY0  = 8;

   typedef enum logic {DIR_UP = 1'b0, DIR_DN = 1'b1} cdir_t;
endpackage

// File: rtl/cpwm3_timebase.sv
module cpwm3_timebase
   import cpwm3_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int SW_W    = 8,
   parameter int PER_RST = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] per_i,
   input  logic             dbl_i,
   input  logic [SW_W-1:0]  syncw_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             down_o,
   output logic             start_o,
   output logic             ld_o,
   output logic             sync_o
);
   cdir_t            dir;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] per_act;
   logic [CNT_W-1:0] per_lim;
   logic [SW_W-1:0]  sc;
   logic             last_up;

   // periods below two would collapse the up/down sequence
   assign per_lim = (per_i < CNT_W'(2)) ? CNT_W'(2) : per_i;
   assign start_o = (dir == DIR_DN) && (cnt == '0);
   assign last_up = (dir == DIR_UP) && (cnt == per_act - CNT_W'(1));
   assign ld_o    = start_o | (dbl_i & last_up);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         dir     <= DIR_DN;
         per_act <= CNT_W'(PER_RST);
      end else if (start_o) begin
         dir     <= DIR_UP;
         per_act <= per_lim;
      end else if (last_up) begin
         dir     <= DIR_DN;
      end else if (dir == DIR_UP) begin
         cnt     <= cnt + CNT_W'(1);
      end else begin
         cnt     <= cnt - CNT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sc <= '0;
      else if (ld_o)
         sc <= (syncw_i == '0) ? SW_W'(1) : syncw_i;
      else if (sc != '0)
         sc <= sc - SW_W'(1);
   end

   assign cnt_o  = cnt;
   assign down_o = (dir == DIR_DN);
   assign sync_o = (sc != '0);
endmodule

// File: rtl/cpwm3_phase.sv
module cpwm3_phase #(
   parameter int CNT_W = 16,
   parameter int DT_W  = 8,
   parameter bit CHOP  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             ld_i,
   input  logic [CNT_W-1:0] duty_i,
   input  logic [DT_W:0]    dt2_i,
   input  logic             en_i,
   input  logic             pol_i,
   input  logic             sr_i,
   input  logic             carrier_i,
   input  logic             chop_hi_i,
   input  logic             chop_lo_i,
   output logic             hi_o,
   output logic             lo_o
);
   localparam logic [DT_W:0] RUN_MAX = '1;

   logic [CNT_W-1:0] duty_act;
   logic             ideal;
   logic             ideal_q;
   logic [DT_W:0]    run_q;
   logic [DT_W:0]    run_eff;
   logic             first;
   logic             settled;
   logic             hi_a;
   logic             lo_a;
   logic             hi_c;
   logic             lo_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         duty_act <= '0;
      else if (ld_i)
         duty_act <= duty_i;
   end

   // centered window: high side wanted while the timer is below the duty
   assign ideal   = (cnt_i < duty_act);
   assign first   = (ideal != ideal_q);
   assign run_eff = first ? '0 : run_q;
   assign settled = (run_eff >= dt2_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ideal_q <= 1'b0;
         run_q   <= '0;
      end else begin
         ideal_q <= ideal;
         if (first)
            run_q <= (DT_W+1)'(1);
         else if (run_q != RUN_MAX)
            run_q <= run_q + (DT_W+1)'(1);
      end
   end

   assign hi_a = ideal & settled;
   assign lo_a = sr_i ? hi_a : (~ideal & settled);

   if (CHOP) begin : g_chop
      assign hi_c = hi_a & (~chop_hi_i | carrier_i);
      assign lo_c = lo_a & (~chop_lo_i | carrier_i);
   end else begin : g_plain
      assign hi_c = hi_a;
      assign lo_c = lo_a;
   end

   assign hi_o = pol_i ? (hi_c & en_i) : ~(hi_c & en_i);
   assign lo_o = pol_i ? (lo_c & en_i) : ~(lo_c & en_i);
endmodule

// File: rtl/cpwm3_top.sv
module cpwm3_top
   import cpwm3_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int DATA_W  = 16,
   parameter int DT_W    = 8,
   parameter int SW_W    = 8,
   parameter int NPH     = 3,
   parameter int PER_RST = 16,
   parameter bit CHOP_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [DATA_W-1:0]   rd_data,
   input  logic                trip_i,
   input  logic                pol_i,
   input  logic                sr_n_i,
   output logic [NPH-1:0]      hi_o,
   output logic [NPH-1:0]      lo_o,
   output logic                sync_o,
   output logic [STAT_W-1:0]   status_o
);
   localparam int CHOP_W = 8;

   if (CNT_W < 4 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must be between 4 and DATA_W");
   end
   if (DATA_W < 16) begin : g_bad_data
      $error("DATA_W must be at least 16");
   end
   if (DT_W < 1 || DT_W >= DATA_W || SW_W < 1 || SW_W > DATA_W) begin : g_bad_dt
      $error("DT_W and SW_W out of range");
   end
   if (NPH < 1 || NPH > 8) begin : g_bad_nph
      $error("NPH must be 1 to 8");
   end
   if (PER_RST < 2 || PER_RST >= (1 << CNT_W)) begin : g_bad_per
      $error("PER_RST out of range");
   end

   logic [DATA_W-1:0] per_r, dead_r, syncw_r, mode_r, gate_r, shdn_r;
   logic [DATA_W-1:0] duty_r [NPH];
   logic              trip_lat;
   logic              run;
   logic              en;
   logic [CNT_W-1:0]  cnt;
   logic              down;
   logic              start;
   logic              ld;
   logic              carrier;
   logic [DT_W:0]     dt2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_r   <= DATA_W'(PER_RST);
         dead_r  <= '0;
         syncw_r <= '0;
         mode_r  <= '0;
         gate_r  <= '0;
         shdn_r  <= '0;
         for (int i = 0; i < NPH; i++) duty_r[i] <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_PERIOD: per_r   <= wr_data;
            A_DEAD:   dead_r  <= wr_data;
            A_SYNCW:  syncw_r <= wr_data;
            A_MODE:   mode_r  <= wr_data;
            A_GATE:   gate_r  <= wr_data;
            A_SHDN:   shdn_r  <= wr_data;
            default: begin
               for (int i = 0; i < NPH; i++)
                  if (wr_addr == ADDR_W'(A_DUTY0 + i)) duty_r[i] <= wr_data;
            end
         endcase
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_PERIOD: rd_data = per_r;
         A_DEAD:   rd_data = dead_r;
         A_SYNCW:  rd_data = syncw_r;
         A_MODE:   rd_data = mode_r;
         A_GATE:   rd_data = gate_r;
         A_SHDN:   rd_data = shdn_r;
         default: begin
            for (int i = 0; i < NPH; i++)
               if (rd_addr == ADDR_W'(A_DUTY0 + i)) rd_data = duty_r[i];
         end
      endcase
   end

   // trip is held until software releases it with a zero in bit 0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         trip_lat <= 1'b0;
      else if (trip_i)
         trip_lat <= 1'b1;
      else if (wr_en && wr_addr == A_SHDN && !wr_data[0])
         trip_lat <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run <= 1'b0;
      else if (trip_i || trip_lat || shdn_r[0])
         run <= 1'b0;
      else if (start)
         run <= 1'b1;
   end

   assign en  = run & ~trip_i & ~shdn_r[0];
   assign dt2 = {dead_r[DT_W-1:0], 1'b0};

   cpwm3_timebase #(
      .CNT_W   (CNT_W),
      .SW_W    (SW_W),
      .PER_RST (PER_RST)
   ) u_tb (
      .clk     (clk),
      .rst_n   (rst_n),
      .per_i   (per_r[CNT_W-1:0]),
      .dbl_i   (mode_r[0]),
      .syncw_i (syncw_r[SW_W-1:0]),
      .cnt_o   (cnt),
      .down_o  (down),
      .start_o (start),
      .ld_o    (ld),
      .sync_o  (sync_o)
   );

   if (CHOP_EN) begin : g_carrier
      logic [CHOP_W-1:0] cc;
      logic              car;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cc  <= '0;
            car <= 1'b0;
         end else if (cc >= gate_r[15:8]) begin
            cc  <= '0;
            car <= ~car;
         end else begin
            cc  <= cc + CHOP_W'(1);
         end
      end
      assign carrier = car;
   end else begin : g_no_carrier
      assign carrier = 1'b1;
   end

   for (genvar p = 0; p < NPH; p++) begin : g_ph
      cpwm3_phase #(
         .CNT_W (CNT_W),
         .DT_W  (DT_W),
         .CHOP  (CHOP_EN)
      ) u_ph (
         .clk       (clk),
         .rst_n     (rst_n),
         .cnt_i     (cnt),
         .ld_i      (ld),
         .duty_i    (duty_r[p][CNT_W-1:0]),
         .dt2_i     (dt2),
         .en_i      (en),
         .pol_i     (pol_i),
         .sr_i      (~sr_n_i),
         .carrier_i (carrier),
         .chop_hi_i (gate_r[0]),
         .chop_lo_i (gate_r[1]),
         .hi_o      (hi_o[p]),
         .lo_o      (lo_o[p])
      );
   end

   assign status_o = {~run, down, sr_n_i, pol_i, trip_i};
endmodule

// File: rtl/cpwm3_chk.sv
module cpwm3_chk #(
   parameter int NPH = 3
) (
   input logic           clk,
   input logic           rst_n,
   input logic           trip,
   input logic           pol,
   input logic           sr_n,
   input logic           dbl,
   input logic           half,
   input logic           sync,
   input logic           sw_sd,
   input logic           gate_same,
   input logic [NPH-1:0] hi,
   input logic [NPH-1:0] lo
);
   logic [NPH-1:0] idle;
   assign idle = {NPH{~pol}};

   a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      sr_n |-> (((hi ^ idle) & (lo ^ idle)) == '0));

   a_r8_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
      trip |-> (hi == idle && lo == idle));

   a_r9_sw_off: assert property (@(posedge clk) disable iff (!rst_n)
      sw_sd |-> (hi == idle && lo == idle));

   a_r11_sr_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (!sr_n && gate_same) |-> (hi == lo));

   a_r7_sync_first_half: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(dbl) && $rose(sync)) |-> !half);
endmodule

bind cpwm3_top cpwm3_chk #(.NPH(NPH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .trip      (trip_i),
   .pol       (pol_i),
   .sr_n      (sr_n_i),
   .dbl       (mode_r[0]),
   .half      (status_o[3]),
   .sync      (sync_o),
   .sw_sd     (shdn_r[0]),
   .gate_same (gate_r[0] == gate_r[1]),
   .hi        (hi_o),
   .lo        (lo_o)
);

// File: tb/cpwm3_top_tb_top.sv
module cpwm3_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        trip = 1'b0;
   logic        pol = 1'b1;
   logic        sr_n = 1'b1;
   logic [2:0]  hi_o, lo_o;
   logic        sync_o;
   logic [4:0]  status_o;

   int checks = 0;
   int errors = 0;
   int hi_n [3];
   int lo_n [3];
   int hi_f [3];
   int syn_r, syn_h, mism, ws_len, pre_act;

   typedef struct packed {
      int per; int dt; int duty; int ehi; int elo;
   } vec_t;
   localparam vec_t VEC [9] = '{
      '{10, 0, 3,  6, 14},
      '{10, 1, 3,  4, 12},
      '{12, 1, 6, 10, 10},
      '{ 8, 2, 5,  6,  2},
      '{10, 0, 0,  0, 20},
      '{10, 0, 10, 20, 0},
      '{10, 0, 15, 20, 0},
      '{10, 3, 12, 20, 0},
      '{10, 3, 0,  0, 20}
   };

   always #5 clk = ~clk;

   cpwm3_top dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .trip_i(trip), .pol_i(pol), .sr_n_i(sr_n), .hi_o(hi_o),
      .lo_o(lo_o), .sync_o(sync_o), .status_o(status_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit any_act();
      return (((hi_o ^ {3{~pol}}) | (lo_o ^ {3{~pol}})) != 3'b000);
   endfunction

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rdchk(input logic [3:0] a, input int exp, input string req);
      rd_addr = a;
      #1;
      chk(rd_data == 16'(exp), req, int'(rd_data), exp);
   endtask

   // advance to the next period start (sync rising in the first half)
   task automatic wait_sync();
      logic sp;
      bit   done;
      sp = sync_o; done = 1'b0; ws_len = 0; pre_act = 0;
      while (!done) begin
         @(negedge clk);
         ws_len++;
         if (sync_o && !sp && !status_o[3]) done = 1'b1;
         else if (any_act()) pre_act++;
         sp = sync_o;
      end
   endtask

   task automatic measure(input int n, input int h, input bit do_wr,
                          input logic [3:0] a, input logic [15:0] d);
      logic sp;
      sp = 1'b0;
      syn_r = 0; syn_h = 0; mism = 0;
      for (int i = 0; i < 3; i++) begin hi_n[i] = 0; lo_n[i] = 0; hi_f[i] = 0; end
      for (int k = 0; k < n; k++) begin
         if (k > 0) @(negedge clk);
         if (k == 0 && do_wr) begin wr_en = 1'b1; wr_addr = a; wr_data = d; end
         if (k == 1) wr_en = 1'b0;
         for (int i = 0; i < 3; i++) begin
            if (hi_o[i] == pol) begin hi_n[i]++; if (k < h) hi_f[i]++; end
            if (lo_o[i] == pol) lo_n[i]++;
         end
         if (hi_o[0] != lo_o[0]) mism++;
         if (sync_o) syn_h++;
         if (sync_o && !sp) syn_r++;
         sp = sync_o;
      end
      wr_en = 1'b0;
   endtask

   task automatic set_all(input int per, input int dt, input int duty);
      wr(4'd0, 16'(per));
      wr(4'd1, 16'(dt));
      for (int i = 0; i < 3; i++) wr(4'(8 + i), 16'(duty));
      wait_sync();
      wait_sync();
   endtask

   initial begin
      #(10 * 150000);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      chk(hi_o == 3'b000 && lo_o == 3'b000, "R1 outputs idle", {hi_o, lo_o}, 0);
      chk(sync_o == 1'b0, "R1 sync low", sync_o, 0);
      chk(status_o[4] == 1'b1, "R1 disabled flag", status_o[4], 1);
      rdchk(4'd0, 16, "R1 period reset");
      rst_n = 1'b1;

      // R13 readback
      wr(4'd0, 16'h000A); wr(4'd1, 16'h1234); wr(4'd2, 16'h00A5);
      wr(4'd3, 16'h0040); wr(4'd4, 16'h5A00); wr(4'd9, 16'h0123);
      rdchk(4'd0, 16'h000A, "R13 read period");
      rdchk(4'd1, 16'h1234, "R13 read dead");
      rdchk(4'd2, 16'h00A5, "R13 read syncw");
      rdchk(4'd3, 16'h0040, "R13 read mode");
      rdchk(4'd4, 16'h5A00, "R13 read gate");
      rdchk(4'd9, 16'h0123, "R13 read duty1");
      wr(4'd2, 16'd3); wr(4'd3, 16'd0); wr(4'd4, 16'd0);

      // R3 R4 R5 vector table
      foreach (VEC[v]) begin
         set_all(VEC[v].per, VEC[v].dt, VEC[v].duty);
         measure(2 * VEC[v].per, 0, 1'b0, 4'd0, 16'd0);
         for (int i = 0; i < 3; i++) begin
            chk(hi_n[i] == VEC[v].ehi, "R3/R4/R5 high count", hi_n[i], VEC[v].ehi);
            chk(lo_n[i] == VEC[v].elo, "R3/R4/R5 low count", lo_n[i], VEC[v].elo);
         end
      end

      // R2 period length
      set_all(10, 0, 3);
      wait_sync();
      chk(ws_len == 20, "R2 period P=10", ws_len, 20);
      set_all(7, 0, 3);
      wait_sync();
      chk(ws_len == 14, "R2 period P=7", ws_len, 14);

      // R13 half flag
      set_all(10, 0, 3);
      chk(status_o[3] == 1'b0, "R13 first half", status_o[3], 0);
      repeat (10) @(negedge clk);
      chk(status_o[3] == 1'b1, "R13 second half", status_o[3], 1);

      // R7 sync rate and width
      wait_sync();
      measure(20, 0, 1'b0, 4'd0, 16'd0);
      chk(syn_r == 1, "R7 single rate", syn_r, 1);
      chk(syn_h == 3, "R7 single width", syn_h, 3);
      wr(4'd3, 16'd1);
      wait_sync(); wait_sync();
      measure(20, 0, 1'b0, 4'd0, 16'd0);
      chk(syn_r == 2, "R7 double rate", syn_r, 2);
      chk(syn_h == 6, "R7 double width", syn_h, 6);

      // R6 update modes
      wr(4'd8, 16'd3);
      wait_sync(); wait_sync();
      measure(20, 10, 1'b1, 4'd8, 16'd6);
      chk(hi_f[0] == 3, "R6 double first half", hi_f[0], 3);
      chk(hi_n[0] - hi_f[0] == 6, "R6 double second half", hi_n[0] - hi_f[0], 6);
      wr(4'd3, 16'd0); wr(4'd8, 16'd3);
      wait_sync(); wait_sync();
      measure(20, 10, 1'b1, 4'd8, 16'd6);
      chk(hi_f[0] == 3, "R6 single first half", hi_f[0], 3);
      chk(hi_n[0] - hi_f[0] == 3, "R6 single second half", hi_n[0] - hi_f[0], 3);

      // R8 trip
      set_all(10, 0, 5);
      repeat (3) @(negedge clk);
      trip = 1'b1;
      #1;
      chk(!any_act(), "R8 immediate off", {hi_o, lo_o}, 0);
      chk(status_o[0] == 1'b1, "R13 trip status", status_o[0], 1);
      repeat (3) @(negedge clk);
      trip = 1'b0;
      wait_sync(); wait_sync();
      measure(20, 0, 1'b0, 4'd0, 16'd0);
      chk(hi_n[0] + lo_n[0] == 0, "R8 stays off", hi_n[0] + lo_n[0], 0);
      chk(status_o[4] == 1'b1, "R8 disabled flag", status_o[4], 1);
      wait_sync();
      repeat (3) @(negedge clk);
      wr(4'd5, 16'd0);
      wait_sync();
      chk(pre_act == 0, "R8 no mid-period restart", pre_act, 0);
      measure(20, 0, 1'b0, 4'd0, 16'd0);
      chk(hi_n[0] == 10, "R8 resumed high", hi_n[0], 10);

      // R9 software shutdown
      wr(4'd5, 16'd1);
      chk(!any_act(), "R9 off after write", {hi_o, lo_o}, 0);
      rdchk(4'd5, 1, "R13 read shutdown");
      measure(20, 0, 1'b0, 4'd0, 16'd0);
      chk(hi_n[2] + lo_n[2] == 0, "R9 stays off", hi_n[2] + lo_n[2], 0);
      wr(4'd5, 16'd0);
      wait_sync();
      chk(pre_act == 0, "R9 waits for boundary", pre_act, 0);
      measure(20, 0, 1'b0, 4'd0, 16'd0);
      chk(lo_n[1] == 10, "R9 resumed low", lo_n[1], 10);

      // R10 polarity
      pol = 1'b0;
      wr(4'd5, 16'd1);
      chk(hi_o == 3'b111 && lo_o == 3'b111, "R10 idle high", {hi_o, lo_o}, 63);
      wr(4'd5, 16'd0);
      wait_sync(); wait_sync();
      measure(20, 0, 1'b0, 4'd0, 16'd0);
      chk(hi_n[0] == 10, "R10 active-low high side", hi_n[0], 10);
      chk(status_o[1] == 1'b0, "R13 pol status", status_o[1], 0);
      pol = 1'b1;

      // R11 switched reluctance
      set_all(10, 1, 3);
      sr_n = 1'b0;
      wait_sync(); wait_sync();
      measure(20, 0, 1'b0, 4'd0, 16'd0);
      chk(mism == 0, "R11 low follows high", mism, 0);
      chk(lo_n[0] == 4, "R11 low count", lo_n[0], 4);
      chk(status_o[2] == 1'b0, "R13 sr status", status_o[2], 0);
      sr_n = 1'b1;

      // R12 gate chopping
      wr(4'd4, 16'h0001);
      set_all(10, 0, 10);
      measure(20, 0, 1'b0, 4'd0, 16'd0);
      chk(hi_n[0] == 10, "R12 high chopped", hi_n[0], 10);
      set_all(10, 0, 0);
      measure(20, 0, 1'b0, 4'd0, 16'd0);
      chk(lo_n[0] == 20, "R12 low unaffected", lo_n[0], 20);
      wr(4'd4, 16'h0102);
      wait_sync();
      measure(20, 0, 1'b0, 4'd0, 16'd0);
      chk(lo_n[0] == 10, "R12 low chopped", lo_n[0], 10);

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule